// File: doc/BRIEF.md
# Two's Complement Sequential Multiplier

This block multiplies two signed two's complement words of `W` bits, one multiplier bit per clock. A pulse on `start` while the unit is idle captures both operands. For each of the `W-1` low multiplier bits, the unit adds either the multiplicand or zero to a running partial product and then shifts it one place to the right. The multiplier's sign bit carries negative weight, so it is not added like the other bits. Instead, a final correction cycle subtracts the multiplicand from the upper half, using its two's complement.

The result is `2W-1` bits wide and sits in two single-length words. `prod_hi` holds the upper `W` bits. The bits that were shifted out of the accumulator fill the low `W-1` positions of `prod_lo`. The top position of `prod_lo` carries no weight: depending on a parameter it reads as zero or as a copy of the sign of `prod_hi`. A run takes `W` busy cycles, and `done` then pulses for one cycle. The result stays on the outputs until the next accepted start.

Top module: `seqmul_tc`

## Requirements
- R1: After reset `busy`, `done`, `prod_hi` and `prod_lo` are all 0.
- R2: When `start` is high at a rising edge while `busy` is 0, `busy` is 1 after that edge and stays 1 for exactly `W` cycles. `done` is 1 only in the cycle after the last busy cycle, that is, after the `W`-th edge following the start edge.
- R3: When `done` is 1, the `2W-1`-bit value `{prod_hi, prod_lo[W-2:0]}` equals the low `2W-1` bits of the signed product of `mcand` and `mplier` (both two's complement), for every combination of operand signs.
- R4: With `LO_SIGN_COPY` = 0, `prod_lo[W-1]` is 0. With `LO_SIGN_COPY` = 1, `prod_lo[W-1]` equals `prod_hi[W-1]`.
- R5: `start` is ignored while `busy` is 1. Changing the operands or raising `start` during a run alters neither the run's length nor its result.
- R6: While the unit is idle and `start` is low, `prod_hi` and `prod_lo` hold their values, even when the operand inputs change.
- R7: `done` is high for a single cycle per run.
- R8: With both operands equal to the most negative value, the result reads as the unsigned value 2^(2W-2): `prod_hi` = 1 followed by `W-1` zeros, and the low `W-1` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | W | Multiplicand, two's complement |
| mplier | input | W | Multiplier, two's complement |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse, result valid |
| prod_hi | output | W | Upper half of the product |
| prod_lo | output | W | Lower product bits plus sign-position bit |

## Verification
Four properties are checked on every cycle. An accepted start makes `busy` rise on the next cycle. A counter in the checker confirms that each run lasts exactly `W` cycles. `done` never stays high for two cycles. The outputs stay frozen whenever the unit is idle and not started. Only the bench's scenarios can show that the arithmetic is correct. These include products across all four sign combinations, the most-negative squared corner case, a start raised during a run, and the two settings of the low sign position.

// File: rtl/seqmul_tc.sv
module seqmul_tc #(
  parameter int W = 8,
  parameter bit LO_SIGN_COPY = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  localparam int CW = $clog2(W);

  logic [W:0]    acc;
  logic [W-2:0]  lo_r;
  logic [W-1:0]  a_r;
  logic [W-1:0]  x_r;
  logic [CW-1:0] step;

  wire         last  = (step == CW'(W-1));
  wire [W:0]   a_ext = {a_r[W-1], a_r};
  wire [W:0]   sum   = acc + (x_r[0] ? a_ext : '0);
  wire [W:0]   fixed = x_r[0] ? (acc - a_ext) : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      lo_r <= '0;
      a_r  <= '0;
      x_r  <= '0;
      step <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          a_r  <= mcand;
          x_r  <= mplier;
          acc  <= '0;
          lo_r <= '0;
          step <= '0;
          busy <= 1'b1;
        end
      end else if (!last) begin
        acc  <= {sum[W], sum[W:1]};
        lo_r <= {sum[0], lo_r[W-2:1]};
        x_r  <= x_r >> 1;
        step <= step + 1'b1;
      end else begin
        acc  <= fixed;
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign prod_hi = acc[W-1:0];
  assign prod_lo = {(LO_SIGN_COPY ? acc[W-1] : 1'b0), lo_r};
endmodule

// File: rtl/seqmul_tc_chk.sv
module seqmul_tc_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] prod_hi,
  input logic [W-1:0] prod_lo
);
  localparam int RW = $clog2(W + 1) + 1;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_len <= '0;
    else if (!busy && start) run_len <= '0;
    else if (busy)           run_len <= run_len + 1'b1;
  end

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r2_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == RW'(W)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo)));
endmodule

bind seqmul_tc seqmul_tc_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
);

// File: tb/seqmul_tc_test.sv
module seqmul_tc_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic busy, done, busy_c, done_c;
  logic [W-1:0] hi, lo, hi_c, lo_c;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  seqmul_tc #(.W(W), .LO_SIGN_COPY(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .prod_hi(hi), .prod_lo(lo));

  seqmul_tc #(.W(W), .LO_SIGN_COPY(1'b1)) uut_c (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy_c), .done(done_c), .prod_hi(hi_c), .prod_lo(lo_c));

  localparam logic [15:0] VEC [16] = '{
    16'h0305, 16'h0503, 16'hFD05, 16'h05FD, 16'hFBFD, 16'h7F7F,
    16'h807F, 16'h7F80, 16'hFFFF, 16'h0080, 16'h8001, 16'h0180,
    16'hFF80, 16'h8000, 16'hA5C3, 16'h3A6B };

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] prod(logic [W-1:0] a, logic [W-1:0] x);
    logic [2*W-1:0] ae, xe;
    ae = {{W{a[W-1]}}, a};
    xe = {{W{x[W-1]}}, x};
    return ae * xe;
  endfunction

  task automatic exp_hi_lo(logic [W-1:0] a, logic [W-1:0] x, bit copy,
                           output logic [W-1:0] eh, output logic [W-1:0] el);
    logic [2*W-1:0] p;
    p = prod(a, x);
    eh = p[2*W-2:W-1];
    el = {(copy ? eh[W-1] : 1'b0), p[W-2:0]};
  endtask

  task automatic run(logic [W-1:0] a, logic [W-1:0] x, bit poke);
    logic [W-1:0] eh, el, ehc, elc;
    exp_hi_lo(a, x, 1'b0, eh, el);
    exp_hi_lo(a, x, 1'b1, ehc, elc);
    @(negedge clk);
    mcand = a; mplier = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", {7'd0, busy}, 8'd1);
    for (int i = 0; i < W - 1; i++) begin
      @(negedge clk);
      if (poke && i == 0) begin
        mcand = ~a; mplier = a ^ x ^ 8'h5A; start = 1'b1;
      end
      if (poke && i == 2) start = 1'b0;
      if (done) chk("R2 early done", {7'd0, done}, 8'd0);
    end
    @(negedge clk);
    chk("R2 done at W", {7'd0, done}, 8'd1);
    chk(poke ? "R5 hi after poke" : "R3 prod_hi", hi, eh);
    chk(poke ? "R5 lo after poke" : "R3 prod_lo", lo, el);
    chk("R4 copy prod_hi", hi_c, ehc);
    chk("R4 copy prod_lo", lo_c, elc);
    @(negedge clk);
    chk("R7 done one cycle", {7'd0, done}, 8'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] h0, l0;
    repeat (3) @(negedge clk);
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 done", {7'd0, done}, 8'd0);
    chk("R1 prod_hi", hi, 8'd0);
    chk("R1 prod_lo", lo, 8'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 16; v++) run(VEC[v][15:8], VEC[v][7:0], 1'b0);

    run(8'h80, 8'h80, 1'b0);
    chk("R8 hi corner", hi, 8'h80);
    chk("R8 lo corner", lo[W-2:0] == '0 ? 8'd0 : 8'd1, 8'd0);

    run(8'hE9, 8'h93, 1'b1);

    h0 = hi; l0 = lo;
    @(negedge clk);
    mcand = 8'h11; mplier = 8'h22;
    repeat (4) @(negedge clk);
    chk("R6 hold hi", hi, h0);
    chk("R6 hold lo", lo, l0);
    chk("R6 idle", {7'd0, busy}, 8'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule